// File: doc/BRIEF.md
# Buffered Modulus Period Counter

This block is the counting core of a timer channel whose period comes from an active compare value fed by a second, buffered value. Software writes a new period into the buffer at any time. The counter keeps using the active value until the current period ends, so a write made mid-period never shortens or stretches the period already running.

Two counting modes are available. In up mode the counter climbs from 1 to the active value and restarts at 1. In up/down mode it climbs to the active value and then descends back to 1. Each time the counter sits at 1, a one-clock reload pulse moves the buffer into the active register, and the new value is visible on the following clock. A freeze input blocks that transfer.

A match between the counter and the active value raises a one-cycle match pulse and sets a sticky flag, which stays set until it is cleared.

Top module: `bmpc_top`

## Requirements
- R1: In up mode (`mode_updown`=0) the count runs 1, 2, …, P and returns to 1 on the clock after it equals the active period P.
- R2: In up/down mode (`mode_updown`=1) the count rises from 1 to P, holds P for exactly one clock, then falls by one each clock down to 1, then rises again; one full cycle lasts 2·(P−1) clocks.
- R3: `reload` is high in exactly the cycles where the count equals 1.
- R4: During a `reload` cycle, `period` still shows the old active value; the transferred value appears on the next clock, and `period` changes at no other time.
- R5: A buffer write (`buf_wr`=1 with `buf_data`) made at any point in a period becomes the active period for the next period.
- R6: A buffer write made in the same clock as `reload` is the value transferred into the active register at that boundary.
- R7: While `upd_freeze` is 1, the active period is not reloaded at the boundary and the period length is unchanged; the buffered value is kept and transfers at the first boundary after the freeze is released.
- R8: `match` is high in the cycles where the count equals the active period, and `flag` becomes 1 on the next clock.
- R9: `flag` stays set until `flag_clr` is pulsed; a clear in the same cycle as a match leaves `flag` set.
- R10: After reset, the count is 1, both the active and buffered periods hold `DEF_PERIOD` (8), and `flag` and `match` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_updown | input | 1 | 0 = up count, 1 = up/down count |
| buf_wr | input | 1 | Buffer write strobe |
| buf_data | input | WIDTH | New period value for the buffer |
| upd_freeze | input | 1 | Blocks the buffer-to-active transfer |
| flag_clr | input | 1 | Clears the sticky flag |
| count | output | WIDTH | Current counter value |
| period | output | WIDTH | Active compare (period) value |
| reload | output | 1 | Boundary transfer pulse (count is 1) |
| match | output | 1 | Count equals the active period |
| flag | output | 1 | Sticky match flag |

## Verification
Up-mode runs with the default period confirm the wrap point. A mid-period write to 5 shows that the running period keeps its length and that only the next one shortens. A write landing in the reload cycle, and a write made under freeze, separate the three possible transfer timings: early, on the boundary, and blocked. The up/down run with period 4 checks that the peak is held for a single clock and that the descent stops at 1. The flag tests tell a sticky set apart from a level copy of `match`, and check the clear-versus-set priority.

// File: rtl/bmpc_pkg.sv
package bmpc_pkg;
    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } bmpc_dir_e;

    typedef enum logic {
        MODE_UP     = 1'b0,
        MODE_UPDOWN = 1'b1
    } bmpc_mode_e;
endpackage

// File: rtl/bmpc_period_regs.sv
module bmpc_period_regs #(
    parameter int WIDTH      = 16,
    parameter int DEF_PERIOD = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             load,
    input  logic             freeze,
    output logic [WIDTH-1:0] active
);
    localparam logic [WIDTH-1:0] DEF_VAL = WIDTH'(DEF_PERIOD);

    logic [WIDTH-1:0] buf_q;
    logic [WIDTH-1:0] buf_next;

    always_comb begin
        buf_next = wr ? wdata : buf_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q  <= DEF_VAL;
            active <= DEF_VAL;
        end else begin
            buf_q <= buf_next;
            if (load && !freeze) begin
                active <= buf_next;
            end
        end
    end
endmodule

// File: rtl/bmpc_count_core.sv
module bmpc_count_core
    import bmpc_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_updown,
    input  logic [WIDTH-1:0] limit,
    output logic [WIDTH-1:0] count,
    output logic             at_one,
    output logic             hit
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    bmpc_dir_e        dir_q, dir_n;
    logic [WIDTH-1:0] cnt_n;
    bmpc_mode_e       mode;

    always_comb begin
        mode   = bmpc_mode_e'(mode_updown);
        at_one = (count == ONE);
        hit    = (count == limit);
        dir_n  = dir_q;
        cnt_n  = count;
        if (mode == MODE_UP) begin
            dir_n = DIR_UP;
            cnt_n = (count >= limit) ? ONE : count + ONE;
        end else if (dir_q == DIR_UP) begin
            if (count >= limit && count > ONE) begin
                dir_n = DIR_DOWN;
                cnt_n = count - ONE;
            end else begin
                cnt_n = count + ONE;
            end
        end else begin
            if (count <= ONE) begin
                dir_n = DIR_UP;
                cnt_n = count + ONE;
            end else begin
                cnt_n = count - ONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= ONE;
            dir_q <= DIR_UP;
        end else begin
            count <= cnt_n;
            dir_q <= dir_n;
        end
    end
endmodule

// File: rtl/bmpc_flag_unit.sv
module bmpc_flag_unit (
    input  logic clk,
    input  logic rst,
    input  logic set_ev,
    input  logic clr,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (set_ev) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end
endmodule

// File: rtl/bmpc_top.sv
module bmpc_top #(
    parameter int WIDTH      = 16,
    parameter int DEF_PERIOD = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_updown,
    input  logic             buf_wr,
    input  logic [WIDTH-1:0] buf_data,
    input  logic             upd_freeze,
    input  logic             flag_clr,
    output logic [WIDTH-1:0] count,
    output logic [WIDTH-1:0] period,
    output logic             reload,
    output logic             match,
    output logic             flag
);
    bmpc_period_regs #(.WIDTH(WIDTH), .DEF_PERIOD(DEF_PERIOD)) u_regs (
        .clk(clk), .rst(rst), .wr(buf_wr), .wdata(buf_data),
        .load(reload), .freeze(upd_freeze), .active(period)
    );

    bmpc_count_core #(.WIDTH(WIDTH)) u_core (
        .clk(clk), .rst(rst), .mode_updown(mode_updown), .limit(period),
        .count(count), .at_one(reload), .hit(match)
    );

    bmpc_flag_unit u_flag (
        .clk(clk), .rst(rst), .set_ev(match), .clr(flag_clr), .flag(flag)
    );
endmodule

// File: rtl/bmpc_checker.sv
module bmpc_checker #(
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             mode_updown,
    input logic             upd_freeze,
    input logic             flag_clr,
    input logic [WIDTH-1:0] count,
    input logic [WIDTH-1:0] period,
    input logic             reload,
    input logic             match,
    input logic             flag
);
    a_r1_up_wrap: assert property (@(posedge clk) disable iff (rst)
        (!mode_updown && match) |=> (count == WIDTH'(1)));

    a_r2_peak_once: assert property (@(posedge clk) disable iff (rst)
        (mode_updown && match && count > WIDTH'(1)) |=> (count == $past(count) - WIDTH'(1)));

    a_r4_period_hold: assert property (@(posedge clk) disable iff (rst)
        !reload |=> $stable(period));

    a_r7_freeze_hold: assert property (@(posedge clk) disable iff (rst)
        upd_freeze |=> $stable(period));

    a_r8_flag_set: assert property (@(posedge clk) disable iff (rst)
        match |=> flag);

    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (flag && !flag_clr) |=> flag);
endmodule

bind bmpc_top bmpc_checker #(.WIDTH(WIDTH)) u_bmpc_checker (
    .clk(clk), .rst(rst), .mode_updown(mode_updown), .upd_freeze(upd_freeze),
    .flag_clr(flag_clr), .count(count), .period(period), .reload(reload),
    .match(match), .flag(flag)
);

// File: tb/bmpc_top_bench.sv
`timescale 1ns/1ps
module bmpc_top_bench;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         mode_updown = 1'b0;
    logic         buf_wr = 1'b0;
    logic [W-1:0] buf_data = '0;
    logic         upd_freeze = 1'b0;
    logic         flag_clr = 1'b0;
    logic [W-1:0] count, period;
    logic         reload, match, flag;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    bmpc_top #(.WIDTH(W), .DEF_PERIOD(8)) u_bmpc_top (
        .clk(clk), .rst(rst), .mode_updown(mode_updown), .buf_wr(buf_wr),
        .buf_data(buf_data), .upd_freeze(upd_freeze), .flag_clr(flag_clr),
        .count(count), .period(period), .reload(reload), .match(match), .flag(flag)
    );

    task automatic chk(input string req, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset(input logic m);
        rst = 1'b1;
        mode_updown = m;
        buf_wr = 1'b0;
        upd_freeze = 1'b0;
        flag_clr = 1'b0;
        tick();
        tick();
        rst = 1'b0;
    endtask

    task automatic wait_one();
        for (int i = 0; i < 100 && count != W'(1); i++) tick();
    endtask

    task automatic t_reset();
        do_reset(1'b0);
        chk("R10 count", int'(count), 1);
        chk("R10 period", int'(period), 8);
        chk("R10 flag", int'(flag), 0);
        chk("R10 match", int'(match), 0);
        chk("R3 reload at one", int'(reload), 1);
    endtask

    task automatic t_up_default();
        do_reset(1'b0);
        for (int k = 1; k <= 20; k++) begin
            tick();
            chk("R1 up count", int'(count), (k % 8) + 1);
            chk("R8 match", int'(match), ((k % 8) == 7) ? 1 : 0);
            chk("R3 reload", int'(reload), ((k % 8) == 0) ? 1 : 0);
            if (k == 7) chk("R8 flag not yet", int'(flag), 0);
            if (k == 8) chk("R8 flag set", int'(flag), 1);
        end
    endtask

    task automatic t_mid_write();
        do_reset(1'b0);
        tick(); tick();
        buf_wr = 1'b1; buf_data = W'(5);
        tick();
        buf_wr = 1'b0;
        chk("R5 period kept mid-period", int'(period), 8);
        wait_one();
        chk("R4 old period during reload", int'(period), 8);
        tick();
        chk("R4 new period next clock", int'(period), 5);
        chk("R5 count after boundary", int'(count), 2);
        tick(); tick(); tick();
        chk("R5 match at new period", int'(match), 1);
        chk("R5 count at new period", int'(count), 5);
        tick();
        chk("R1 wrap at new period", int'(count), 1);
        // write landing in the reload cycle
        buf_wr = 1'b1; buf_data = W'(6);
        tick();
        buf_wr = 1'b0;
        chk("R6 same-cycle write transferred", int'(period), 6);
        // freeze blocks the transfer
        upd_freeze = 1'b1;
        buf_wr = 1'b1; buf_data = W'(3);
        tick();
        buf_wr = 1'b0;
        wait_one();
        tick();
        chk("R7 frozen period", int'(period), 6);
        for (int i = 0; i < 4; i++) tick();
        chk("R7 frozen length count", int'(count), 6);
        chk("R7 frozen length match", int'(match), 1);
        upd_freeze = 1'b0;
        tick();
        chk("R7 boundary after release", int'(count), 1);
        tick();
        chk("R7 buffered value after release", int'(period), 3);
    endtask

    task automatic t_updown();
        int exp_seq[12] = '{2, 3, 4, 3, 2, 1, 2, 3, 4, 3, 2, 1};
        do_reset(1'b1);
        buf_wr = 1'b1; buf_data = W'(4);
        tick();
        buf_wr = 1'b0;
        chk("R6 reset-cycle write", int'(period), 4);
        for (int i = 0; i < 12; i++) begin
            chk("R2 updown count", int'(count), exp_seq[i]);
            chk("R8 updown match", int'(match), (exp_seq[i] == 4) ? 1 : 0);
            chk("R3 updown reload", int'(reload), (exp_seq[i] == 1) ? 1 : 0);
            tick();
        end
    endtask

    task automatic t_flag();
        do_reset(1'b0);
        for (int i = 0; i < 8; i++) tick();
        chk("R9 flag set", int'(flag), 1);
        tick(); tick(); tick();
        chk("R9 flag sticky", int'(flag), 1);
        flag_clr = 1'b1;
        tick();
        flag_clr = 1'b0;
        chk("R9 flag cleared", int'(flag), 0);
        for (int i = 0; i < 100 && !match; i++) tick();
        flag_clr = 1'b1;
        tick();
        flag_clr = 1'b0;
        chk("R9 set wins over clear", int'(flag), 1);
    endtask

    initial begin
        #400000;
        bad++;
        total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_up_default();
        t_mid_write();
        t_updown();
        t_flag();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule